// File: doc/BRIEF.md
# Two-Bank Exception Activation Tracker

This block keeps per-exception state for a small interrupt controller that holds two copies of its vector state, a secure bank and a non-secure bank. A fixed parameter mask names the exception numbers that are banked: each of these has an independent entry in both banks. Every other number has one real entry, held in the non-secure bank. For each entry the block stores a pending bit and an active bit. Enable bits and the per-exception secure-target configuration come in as level inputs.

Arbitration lives outside the block. The caller presents an acknowledge request carrying the winning exception number, its priority and a flag saying whether it came from the secure bank. On success the chosen entry moves from pending to active, the number becomes the current exception, and the block reports the security state the exception must be taken in. A failed check raises an error pulse instead. A complete request carries an exception number and a security flag. The block clears the selected active bit, or reports an illegal return if that bit was already clear. A pend-set strobe lets the surroundings mark exceptions pending. An interrupt output follows the enabled-and-pending state of both banks.

Top module: `bex_unit`

## Requirements
- R1: An acknowledge whose number is 0, 1 (reset) or not below NUM_EXC raises `ack_err` one cycle later and changes no pending or active bit.
- R2: An acknowledge with `ack_sbank`=1 works on the secure-bank entry and reports `ack_to_sec`=1.
- R3: An acknowledge with `ack_sbank`=0 works on the non-secure entry. It reports `ack_to_sec`=1 only when the number is not in BANKED and its `tgt_sec` bit is 1.
- R4: An acknowledge succeeds only if the selected entry is enabled and pending and `ack_prio` < `exec_prio`. Otherwise `ack_err` pulses and no pending or active bit changes.
- R5: A successful acknowledge sets the selected active bit and clears the selected pending bit at the next edge. At the same edge it loads `cur_exc` with the number and raises `ack_done` for exactly one cycle.
- R6: `irq_out` is 1 exactly when some entry is both enabled and pending in either bank, and it follows state changes made by an acknowledge.
- R7: A complete uses the secure-bank entry only when `cmp_sec`=1 and the number is in BANKED. Otherwise it uses the non-secure entry.
- R8: A complete whose selected entry is not active, or whose number is out of range, raises `cmp_illegal` one cycle later and leaves all state unchanged.
- R9: A successful complete clears the selected active bit at the next edge and raises `cmp_done` for one cycle.
- R10: When acknowledge and complete requests arrive in the same cycle, the complete is executed first and the acknowledge is executed one cycle later.
- R11: `set_vld` marks `set_num` pending. It uses the secure bank when `set_sec`=1 and the number is banked, and the non-secure bank otherwise.
- R12: After reset all pending and active bits, `cur_exc` and all response pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_ns | input | NUM_EXC | Enable bits, non-secure bank |
| en_s | input | NUM_EXC | Enable bits, secure bank |
| tgt_sec | input | NUM_EXC | Secure-target configuration per exception |
| exec_prio | input | PRIO_W | Current execution priority (lower is more urgent) |
| set_vld | input | 1 | Mark an exception pending |
| set_num | input | NUM_W | Exception number to mark pending |
| set_sec | input | 1 | Pend-set targets the secure bank |
| ack_req | input | 1 | Acknowledge request |
| ack_num | input | NUM_W | Exception number to acknowledge |
| ack_prio | input | PRIO_W | Priority of that exception |
| ack_sbank | input | 1 | Pending exception comes from the secure bank |
| cmp_req | input | 1 | Complete request |
| cmp_num | input | NUM_W | Exception number to complete |
| cmp_sec | input | 1 | Caller's security state for the complete |
| ack_done | output | 1 | Acknowledge succeeded (one-cycle pulse) |
| ack_err | output | 1 | Acknowledge rejected (one-cycle pulse) |
| ack_to_sec | output | 1 | Exception must be taken in secure state |
| cur_exc | output | NUM_W | Number of the last acknowledged exception |
| cmp_done | output | 1 | Complete succeeded (one-cycle pulse) |
| cmp_illegal | output | 1 | Illegal exception return (one-cycle pulse) |
| irq_out | output | 1 | Some enabled entry is pending |
| pend_ns | output | NUM_EXC | Pending bits, non-secure bank |
| pend_s | output | NUM_EXC | Pending bits, secure bank |
| act_ns | output | NUM_EXC | Active bits, non-secure bank |
| act_s | output | NUM_EXC | Active bits, secure bank |

## Verification
The bench builds the block with NUM_EXC=16, a 4-bit priority and BANKED=16'h004C, which makes numbers 2, 3 and 6 banked. The number ports are then 5 bits wide. That lets the bench present 16, one past the top entry, as well as the reset number 1, so both ends of the range check can be reached. Number 3 is both banked and marked secure-target, so one entry shows the banked rule overriding the target bit. Number 7 is non-banked and secure-target, and it shows a secure flag on a complete falling back to the non-secure bank.

// File: rtl/bex_pkg.sv
// Package: shared types for the two-bank exception tracker.
package bex_pkg;
    // Which bank of vector state an operation touches.
    typedef enum logic {
        BANK_NS = 1'b0,
        BANK_S  = 1'b1
    } bank_e;
endpackage

// File: rtl/bex_bank.sv
// Module: one bank of pending/active state.
// Assumes: a set and a clear of the same active bit never arrive in the same cycle.
// When a pending bit is set and cleared together, the set wins.
module bex_bank #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend_set,
    input  logic [N-1:0] pend_clr,
    input  logic [N-1:0] act_set,
    input  logic [N-1:0] act_clr,
    output logic [N-1:0] pend,
    output logic [N-1:0] act
);
    for (genvar i = 0; i < N; i++) begin : g_entry
        // Per-entry pending flag: set dominates clear.
        always_ff @(posedge clk) begin
            if (!rst_n)           pend[i] <= 1'b0;
            else if (pend_set[i]) pend[i] <= 1'b1;
            else if (pend_clr[i]) pend[i] <= 1'b0;
        end

        // Per-entry active flag.
        always_ff @(posedge clk) begin
            if (!rst_n)          act[i] <= 1'b0;
            else if (act_set[i]) act[i] <= 1'b1;
            else if (act_clr[i]) act[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/bex_ack_dec.sv
// Module: combinational acknowledge decision.
// Picks the bank, checks range, enable, pending and priority, and works out
// the target security state. Assumes NW bits can hold NUM_EXC.
module bex_ack_dec
    import bex_pkg::*;
#(
    parameter int           N      = 32,
    parameter int           NW     = 6,
    parameter int           PW     = 8,
    parameter logic [N-1:0] BANKED = '0
) (
    input  logic [NW-1:0] num,
    input  logic [PW-1:0] prio,
    input  logic          sbank,
    input  logic [PW-1:0] exec_prio,
    input  logic [N-1:0]  en_ns,
    input  logic [N-1:0]  en_s,
    input  logic [N-1:0]  pend_ns,
    input  logic [N-1:0]  pend_s,
    input  logic [N-1:0]  tgt_sec,
    output logic          ok,
    output logic          to_sec,
    output bank_e         bank,
    output logic [N-1:0]  onehot
);
    logic in_range, is_banked, is_en, is_pend, prio_ok;

    // Decode the number and evaluate every acceptance condition.
    always_comb begin
        onehot    = {{(N-1){1'b0}}, 1'b1} << num;
        in_range  = (num > NW'(1)) && (num < NW'(N));
        is_banked = |(onehot & BANKED);
        bank      = sbank ? BANK_S : BANK_NS;
        is_en     = |(onehot & ((bank == BANK_S) ? en_s : en_ns));
        is_pend   = |(onehot & ((bank == BANK_S) ? pend_s : pend_ns));
        prio_ok   = prio < exec_prio;
        ok        = in_range && is_en && is_pend && prio_ok;
        to_sec    = sbank || (!is_banked && |(onehot & tgt_sec));
    end
endmodule

// File: rtl/bex_cmp_dec.sv
// Module: combinational complete decision.
// Selects the bank from the caller's flag and the banked mask, and checks
// that the selected entry is active.
module bex_cmp_dec
    import bex_pkg::*;
#(
    parameter int           N      = 32,
    parameter int           NW     = 6,
    parameter logic [N-1:0] BANKED = '0
) (
    input  logic [NW-1:0] num,
    input  logic          sec,
    input  logic [N-1:0]  act_ns,
    input  logic [N-1:0]  act_s,
    output logic          ok,
    output bank_e         bank,
    output logic [N-1:0]  onehot
);
    logic in_range;

    // Pick the bank and test the active bit.
    always_comb begin
        onehot   = {{(N-1){1'b0}}, 1'b1} << num;
        in_range = (num > NW'(1)) && (num < NW'(N));
        bank     = (sec && |(onehot & BANKED)) ? BANK_S : BANK_NS;
        ok       = in_range && |(onehot & ((bank == BANK_S) ? act_s : act_ns));
    end
endmodule

// File: rtl/bex_unit.sv
// Module: two-bank exception acknowledge/complete tracker (top).
// Assumes the caller keeps acknowledge and complete apart. If they collide,
// the complete runs and the acknowledge waits one cycle in a hold register.
// A fresh acknowledge arriving while one is held is dropped.
module bex_unit
    import bex_pkg::*;
#(
    parameter int              NUM_EXC = 32,
    parameter int              PRIO_W  = 8,
    parameter logic [NUM_EXC-1:0] BANKED = 32'h0000_004C,
    localparam int             NUM_W   = $clog2(NUM_EXC) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXC-1:0] en_ns,
    input  logic [NUM_EXC-1:0] en_s,
    input  logic [NUM_EXC-1:0] tgt_sec,
    input  logic [PRIO_W-1:0]  exec_prio,
    input  logic               set_vld,
    input  logic [NUM_W-1:0]   set_num,
    input  logic               set_sec,
    input  logic               ack_req,
    input  logic [NUM_W-1:0]   ack_num,
    input  logic [PRIO_W-1:0]  ack_prio,
    input  logic               ack_sbank,
    input  logic               cmp_req,
    input  logic [NUM_W-1:0]   cmp_num,
    input  logic               cmp_sec,
    output logic               ack_done,
    output logic               ack_err,
    output logic               ack_to_sec,
    output logic [NUM_W-1:0]   cur_exc,
    output logic               cmp_done,
    output logic               cmp_illegal,
    output logic               irq_out,
    output logic [NUM_EXC-1:0] pend_ns,
    output logic [NUM_EXC-1:0] pend_s,
    output logic [NUM_EXC-1:0] act_ns,
    output logic [NUM_EXC-1:0] act_s
);
    localparam int N = NUM_EXC;

    // Held acknowledge after a collision.
    logic              hold_vld;
    logic [NUM_W-1:0]  hold_num;
    logic [PRIO_W-1:0] hold_prio;
    logic              hold_sbank;

    // Effective acknowledge request (held one first).
    logic              e_vld;
    logic [NUM_W-1:0]  e_num;
    logic [PRIO_W-1:0] e_prio;
    logic              e_sbank;
    logic              run_ack;

    // Decoder results.
    logic          a_ok, a_to_sec, c_ok;
    bank_e         a_bank, c_bank;
    logic [N-1:0]  a_oh, c_oh, s_oh;
    logic          s_to_sec;

    // Bank controls.
    logic [N-1:0] ns_pset, ns_pclr, ns_aset, ns_aclr;
    logic [N-1:0] s_pset,  s_pclr,  s_aset,  s_aclr;

    // Choose between the held acknowledge and the live one.
    always_comb begin
        e_vld   = hold_vld | ack_req;
        e_num   = hold_vld ? hold_num   : ack_num;
        e_prio  = hold_vld ? hold_prio  : ack_prio;
        e_sbank = hold_vld ? hold_sbank : ack_sbank;
        run_ack = e_vld && !cmp_req;
    end

    // Capture an acknowledge that loses to a complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld   <= 1'b0;
            hold_num   <= '0;
            hold_prio  <= '0;
            hold_sbank <= 1'b0;
        end else if (e_vld && cmp_req) begin
            hold_vld   <= 1'b1;
            hold_num   <= e_num;
            hold_prio  <= e_prio;
            hold_sbank <= e_sbank;
        end else begin
            hold_vld   <= 1'b0;
        end
    end

    bex_ack_dec #(.N(N), .NW(NUM_W), .PW(PRIO_W), .BANKED(BANKED)) u_ack_dec (
        .num       (e_num),
        .prio      (e_prio),
        .sbank     (e_sbank),
        .exec_prio (exec_prio),
        .en_ns     (en_ns),
        .en_s      (en_s),
        .pend_ns   (pend_ns),
        .pend_s    (pend_s),
        .tgt_sec   (tgt_sec),
        .ok        (a_ok),
        .to_sec    (a_to_sec),
        .bank      (a_bank),
        .onehot    (a_oh)
    );

    bex_cmp_dec #(.N(N), .NW(NUM_W), .BANKED(BANKED)) u_cmp_dec (
        .num    (cmp_num),
        .sec    (cmp_sec),
        .act_ns (act_ns),
        .act_s  (act_s),
        .ok     (c_ok),
        .bank   (c_bank),
        .onehot (c_oh)
    );

    // Route pend-set, acknowledge and complete effects to the two banks.
    always_comb begin
        s_oh     = {{(N-1){1'b0}}, 1'b1} << set_num;
        s_to_sec = set_sec && |(s_oh & BANKED);
        ns_pset  = (set_vld && !s_to_sec) ? s_oh : '0;
        s_pset   = (set_vld &&  s_to_sec) ? s_oh : '0;
        ns_pclr  = (run_ack && a_ok && a_bank == BANK_NS) ? a_oh : '0;
        s_pclr   = (run_ack && a_ok && a_bank == BANK_S)  ? a_oh : '0;
        ns_aset  = ns_pclr;
        s_aset   = s_pclr;
        ns_aclr  = (cmp_req && c_ok && c_bank == BANK_NS) ? c_oh : '0;
        s_aclr   = (cmp_req && c_ok && c_bank == BANK_S)  ? c_oh : '0;
    end

    for (genvar b = 0; b < 2; b++) begin : g_bank
        if (b == 0) begin : g_ns
            bex_bank #(.N(N)) u_bank (
                .clk (clk), .rst_n (rst_n),
                .pend_set (ns_pset), .pend_clr (ns_pclr),
                .act_set  (ns_aset), .act_clr  (ns_aclr),
                .pend (pend_ns), .act (act_ns)
            );
        end else begin : g_s
            bex_bank #(.N(N)) u_bank (
                .clk (clk), .rst_n (rst_n),
                .pend_set (s_pset), .pend_clr (s_pclr),
                .act_set  (s_aset), .act_clr  (s_aclr),
                .pend (pend_s), .act (act_s)
            );
        end
    end

    // Register response pulses and the current exception number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_done    <= 1'b0;
            ack_err     <= 1'b0;
            ack_to_sec  <= 1'b0;
            cur_exc     <= '0;
            cmp_done    <= 1'b0;
            cmp_illegal <= 1'b0;
        end else begin
            ack_done    <= run_ack && a_ok;
            ack_err     <= run_ack && !a_ok;
            ack_to_sec  <= run_ack && a_ok && a_to_sec;
            if (run_ack && a_ok) cur_exc <= e_num;
            cmp_done    <= cmp_req && c_ok;
            cmp_illegal <= cmp_req && !c_ok;
        end
    end

    // Interrupt request from enabled and pending entries of both banks.
    assign irq_out = |(en_ns & pend_ns) | |(en_s & pend_s);
endmodule

// File: rtl/bex_unit_chk.sv
// Checker: temporal properties of bex_unit, attached with bind.
module bex_unit_chk #(
    parameter int N  = 32,
    parameter int NW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack_done,
    input logic          ack_err,
    input logic          cmp_done,
    input logic          cmp_illegal,
    input logic [NW-1:0] cur_exc,
    input logic [N-1:0]  act_ns,
    input logic [N-1:0]  act_s
);
    // R5: a success pulse and an error pulse never coincide.
    a_r5_ack_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_done && ack_err));

    // R9: done and illegal never coincide for a complete.
    a_r9_cmp_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmp_done && cmp_illegal));

    // R5: after a successful acknowledge the current exception is active in some bank.
    a_r5_active_set: assert property (@(posedge clk) disable iff (!rst_n)
        ack_done |-> |((act_ns | act_s) & ({{(N-1){1'b0}}, 1'b1} << cur_exc)));

    // R4: a rejected acknowledge leaves the active bits alone.
    a_r4_err_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err |-> ($stable(act_ns) && $stable(act_s)));

    // R8: an illegal return leaves the active bits alone.
    a_r8_illegal_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_illegal |-> ($stable(act_ns) && $stable(act_s)));

    // R10: an acknowledge never completes in the same cycle as a complete.
    a_r10_serialised: assert property (@(posedge clk) disable iff (!rst_n)
        !((ack_done || ack_err) && (cmp_done || cmp_illegal)));
endmodule

bind bex_unit bex_unit_chk #(.N(NUM_EXC), .NW(NUM_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_done    (ack_done),
    .ack_err     (ack_err),
    .cmp_done    (cmp_done),
    .cmp_illegal (cmp_illegal),
    .cur_exc     (cur_exc),
    .act_ns      (act_ns),
    .act_s       (act_s)
);

// File: tb/tb_bex_unit.sv
// Directed bench for bex_unit: one task per scenario.
module tb_bex_unit;
    localparam int          N  = 16;
    localparam int          PW = 4;
    localparam int          NW = $clog2(N) + 1;
    localparam logic [N-1:0] BK = 16'h004C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] en_ns = '0, en_s = '0, tgt_sec = '0;
    logic [PW-1:0] exec_prio = '0;
    logic set_vld = 1'b0, set_sec = 1'b0;
    logic [NW-1:0] set_num = '0;
    logic ack_req = 1'b0, ack_sbank = 1'b0;
    logic [NW-1:0] ack_num = '0;
    logic [PW-1:0] ack_prio = '0;
    logic cmp_req = 1'b0, cmp_sec = 1'b0;
    logic [NW-1:0] cmp_num = '0;
    logic ack_done, ack_err, ack_to_sec, cmp_done, cmp_illegal, irq_out;
    logic [NW-1:0] cur_exc;
    logic [N-1:0] pend_ns, pend_s, act_ns, act_s;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    bex_unit #(.NUM_EXC(N), .PRIO_W(PW), .BANKED(BK)) dut (
        .clk, .rst_n, .en_ns, .en_s, .tgt_sec, .exec_prio,
        .set_vld, .set_num, .set_sec,
        .ack_req, .ack_num, .ack_prio, .ack_sbank,
        .cmp_req, .cmp_num, .cmp_sec,
        .ack_done, .ack_err, .ack_to_sec, .cur_exc,
        .cmp_done, .cmp_illegal, .irq_out,
        .pend_ns, .pend_s, .act_ns, .act_s
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_set(input int num, input logic sec);
        @(negedge clk);
        set_vld = 1'b1; set_num = NW'(num); set_sec = sec;
        @(negedge clk);
        set_vld = 1'b0;
    endtask

    task automatic do_ack(input int num, input int prio, input logic sb);
        @(negedge clk);
        ack_req = 1'b1; ack_num = NW'(num); ack_prio = PW'(prio); ack_sbank = sb;
        @(negedge clk);
        ack_req = 1'b0;
    endtask

    task automatic do_cmp(input int num, input logic sec);
        @(negedge clk);
        cmp_req = 1'b1; cmp_num = NW'(num); cmp_sec = sec;
        @(negedge clk);
        cmp_req = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12", "pend_ns", 32'(pend_ns), 0);
        chk("R12", "pend_s", 32'(pend_s), 0);
        chk("R12", "act_ns|act_s", 32'(act_ns | act_s), 0);
        chk("R12", "cur_exc", 32'(cur_exc), 0);
        chk("R12", "pulses", 32'({ack_done, ack_err, cmp_done, cmp_illegal}), 0);
        chk("R6", "irq idle", 32'(irq_out), 0);
    endtask

    task automatic t_pend_set();
        do_set(5, 1'b0);
        chk("R11", "pend_ns after 5", 32'(pend_ns), 32'h0020);
        chk("R6", "irq on pending", 32'(irq_out), 1);
        do_set(3, 1'b1);
        chk("R11", "banked to secure", 32'(pend_s), 32'h0008);
        do_set(7, 1'b1);
        chk("R11", "non-banked stays ns", 32'(pend_ns), 32'h00A0);
        do_set(3, 1'b0);
        do_set(9, 1'b0);
        chk("R11", "pend_ns final", 32'(pend_ns), 32'h02A8);
        chk("R11", "pend_s final", 32'(pend_s), 32'h0008);
    endtask

    task automatic t_ack_basic();
        do_ack(5, 2, 1'b0);
        chk("R5", "ack_done", 32'(ack_done), 1);
        chk("R3", "to_sec ns target", 32'(ack_to_sec), 0);
        chk("R5", "cur_exc", 32'(cur_exc), 5);
        chk("R5", "act_ns", 32'(act_ns), 32'h0020);
        chk("R5", "pend_ns", 32'(pend_ns), 32'h0288);
        @(negedge clk);
        chk("R5", "pulse width", 32'(ack_done), 0);
    endtask

    task automatic t_ack_target();
        do_ack(7, 2, 1'b0);
        chk("R3", "non-banked secure target", 32'(ack_to_sec), 1);
        do_ack(3, 2, 1'b0);
        chk("R3", "banked ns bank not secure", 32'(ack_to_sec), 0);
        chk("R3", "act_ns", 32'(act_ns), 32'h00A8);
        chk("R3", "pend_ns", 32'(pend_ns), 32'h0200);
    endtask

    task automatic t_ack_secure();
        do_ack(3, 1, 1'b1);
        chk("R2", "done", 32'(ack_done), 1);
        chk("R2", "to_sec", 32'(ack_to_sec), 1);
        chk("R2", "act_s", 32'(act_s), 32'h0008);
        chk("R2", "pend_s", 32'(pend_s), 0);
        chk("R2", "act_ns untouched", 32'(act_ns), 32'h00A8);
        chk("R6", "irq off, only disabled pending", 32'(irq_out), 0);
    endtask

    task automatic t_ack_errors();
        do_ack(9, 1, 1'b0);
        chk("R4", "disabled err", 32'(ack_err), 1);
        chk("R4", "disabled pend kept", 32'(pend_ns), 32'h0200);
        do_set(10, 1'b0);
        chk("R6", "irq on after pend 10", 32'(irq_out), 1);
        do_ack(10, 8, 1'b0);
        chk("R4", "equal prio err", 32'(ack_err), 1);
        chk("R4", "equal prio state", 32'(pend_ns), 32'h0600);
        do_ack(4, 1, 1'b0);
        chk("R4", "not pending err", 32'(ack_err), 1);
        do_ack(1, 1, 1'b0);
        chk("R1", "reset number err", 32'(ack_err), 1);
        do_ack(16, 1, 1'b0);
        chk("R1", "above range err", 32'(ack_err), 1);
        chk("R1", "cur_exc kept", 32'(cur_exc), 3);
        chk("R1", "act kept", 32'({act_s, act_ns}), 32'h0008_00A8);
    endtask

    task automatic t_complete();
        do_cmp(3, 1'b1);
        chk("R9", "done", 32'(cmp_done), 1);
        chk("R7", "secure banked clears act_s", 32'(act_s), 0);
        chk("R7", "act_ns kept", 32'(act_ns), 32'h00A8);
        do_cmp(7, 1'b1);
        chk("R7", "non-banked uses ns", 32'(act_ns), 32'h0028);
        do_cmp(3, 1'b0);
        chk("R7", "ns bank 3", 32'(act_ns), 32'h0020);
        do_cmp(3, 1'b0);
        chk("R8", "illegal", 32'(cmp_illegal), 1);
        chk("R8", "no done", 32'(cmp_done), 0);
        chk("R8", "state kept", 32'(act_ns), 32'h0020);
        do_cmp(0, 1'b0);
        chk("R8", "out of range illegal", 32'(cmp_illegal), 1);
    endtask

    task automatic t_collision();
        @(negedge clk);
        ack_req = 1'b1; ack_num = NW'(10); ack_prio = PW'(7); ack_sbank = 1'b0;
        cmp_req = 1'b1; cmp_num = NW'(5); cmp_sec = 1'b0;
        @(negedge clk);
        ack_req = 1'b0; cmp_req = 1'b0;
        chk("R10", "complete first", 32'(cmp_done), 1);
        chk("R10", "ack waits", 32'({ack_done, ack_err}), 0);
        chk("R10", "act_ns after cmp", 32'(act_ns), 0);
        @(negedge clk);
        chk("R10", "ack next cycle", 32'(ack_done), 1);
        chk("R10", "cur_exc", 32'(cur_exc), 10);
        chk("R10", "act_ns", 32'(act_ns), 32'h0400);
        chk("R10", "pend_ns", 32'(pend_ns), 32'h0200);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        en_ns = 16'hFDFF; en_s = 16'h004C; tgt_sec = 16'h00C8; exec_prio = PW'(8);
        t_pend_set();
        t_ack_basic();
        t_ack_target();
        t_ack_secure();
        t_ack_errors();
        t_complete();
        t_collision();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule